// File: doc/BRIEF.md
# Banked UART Configuration Register File

This block holds the configuration state of a 16550-style serial port with extended features. Eight host addresses carry more than eight registers. Which register an address reaches depends on the current line-control value and on two unlock bits.

The layers of access work as follows. Setting line-control bit 7 swaps the baud divisor bytes into the two lowest addresses. Loading line control with the key value BFh also exposes the extended-feature register and the mode register. Bit 4 of the extended-feature register opens the protected fields of the interrupt-enable, modem-control and FIFO-control registers. If modem-control bit 6 is also set, the two FIFO threshold registers replace the modem-status and scratch addresses.

The block drives:
- a break force for the transmit line,
- a transmit hold from auto-CTS,
- the 16-bit baud divisor,
- the FIFO-control byte,
- a core-enable derived from the mode register.

A timed software reset returns every register to its disabled default. A busy/done pair of status bits reports its progress.

Top module: `uart_cfg_bank`

## Requirements
- R1: After rst_n, line control, divisor, interrupt enable, modem control, FIFO control, extended features, thresholds and scratch are all 00h. The mode field is 7h, core_en is 0, tx_break is 0 and sys_stat bit 0 is 1.
- R2: While line-control bit 7 is 1, address 0 reaches the divisor low byte and address 1 the high byte. baud_div is {high, low} and changes only when one of these bytes is written.
- R3: While line-control bit 7 is 0, address 0 reads 00h, address 1 reaches interrupt enable, and address 3 always reaches line control.
- R4: While line control equals BFh, address 2 reaches the extended-feature register and address 4 the 3-bit mode field. Otherwise address 2 reads 01h (no interrupt pending) and address 4 reaches modem control.
- R5: Interrupt-enable bits 7:4 and modem-control bits 7:5 take a write only while extended-feature bit 4 is 1. The lower bits always take a write.
- R6: A write to address 2 outside key mode loads the FIFO-control byte (output fifo_cfg) only while extended-feature bit 4 is 1.
- R7: With extended-feature bit 4 = 1, modem-control bit 6 = 1 and line-control bit 7 = 0, addresses 6 and 7 reach the pause/resume threshold and trigger-level registers. Otherwise address 6 reads 00h and ignores writes, and address 7 is a plain scratch byte, never the hidden threshold.
- R8: tx_break equals line-control bit 6 whatever cts_n is, even with auto-CTS (extended-feature bit 7) on. tx_hold is extended-feature bit 7 AND cts_n.
- R9: core_en is 1 only while the mode field is 0.
- R10: A pulse on soft_reset_wr starts a reset lasting RST_CYCLES clocks.
  - During the reset, sys_ctrl bit 1 reads 1 and sys_stat bit 0 reads 0, and host writes are ignored.
  - Afterwards bit 1 clears itself, bit 0 returns to 1, and all registers hold their R1 defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| soft_reset_wr | input | 1 | Host write of 1 to the soft-reset control bit |
| sys_ctrl | output | 8 | Control readback; bit 1 = reset in progress |
| sys_stat | output | 8 | Status; bit 0 = reset done |
| cts_n | input | 1 | Clear-to-send, active low |
| tx_break | output | 1 | Force transmit line to spacing level |
| tx_hold | output | 1 | Auto-CTS transmit hold |
| core_en | output | 1 | Serial core enabled |
| baud_div | output | 16 | Baud divisor |
| fifo_cfg | output | 8 | FIFO-control byte |

## Verification
The checker assumes the following about the host:
- it raises host_we for one cycle per access;
- it never pulses soft_reset_wr while a reset is already running;
- it changes the address and data only away from the clock edge.

The bench drives every input at the falling edge, issues each write as a single-cycle strobe, and issues the soft reset once from an idle state. With the stimulus kept inside these limits, each stability property ties a register change to a legal write in the matching mode and to nothing else.

// File: rtl/uart_cfg_pkg.sv
// Package: shared constants, register targets and the register-set record
// for the banked serial-port configuration block.
package uart_cfg_pkg;

    localparam int          DW      = 8;
    localparam int          AW      = 3;
    localparam logic [7:0]  ENH_KEY = 8'hBF;
    localparam logic [2:0]  MODE_OFF = 3'h7;

    // Register a decoded address reaches (write and read sides differ).
    typedef enum logic [3:0] {
        TG_NONE, TG_DLL, TG_DLH, TG_IER, TG_FCR, TG_LCR, TG_MCR,
        TG_EFR,  TG_MDR, TG_TCR, TG_TLR, TG_SPR, TG_IIR, TG_ZERO
    } tgt_e;

    typedef struct packed {
        logic [7:0] dll;
        logic [7:0] dlh;
        logic [7:0] ier;
        logic [7:0] fcr;
        logic [7:0] lcr;
        logic [7:0] mcr;
        logic [7:0] efr;
        logic [2:0] mdr;
        logic [7:0] tcr;
        logic [7:0] tlr;
        logic [7:0] spr;
    } regs_t;

    localparam regs_t REGS_RST = '{
        dll: 8'h00, dlh: 8'h00, ier: 8'h00, fcr: 8'h00, lcr: 8'h00,
        mcr: 8'h00, efr: 8'h00, mdr: MODE_OFF, tcr: 8'h00, tlr: 8'h00,
        spr: 8'h00
    };

endpackage

// File: rtl/uart_cfg_decode.sv
// Module: address decoder. Maps the 3-bit address to a write target and a
// read target from the current line-control value and the unlock bits.
// Assumes: purely combinational; key mode implies divisor mode (BFh bit 7 = 1).
module uart_cfg_decode
    import uart_cfg_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [7:0]    lcr,
    input  logic          efr_unlock,
    input  logic          mcr_trig,
    output tgt_e          wr_tgt,
    output tgt_e          rd_tgt
);
    logic key_mode;
    logic div_mode;
    logic trig_vis;

    // Mode flags derived from line control and unlock bits.
    always_comb begin
        key_mode = (lcr == ENH_KEY);
        div_mode = lcr[7];
        trig_vis = efr_unlock & mcr_trig & ~lcr[7];
    end

    // Per-address target selection.
    always_comb begin
        wr_tgt = TG_NONE;
        rd_tgt = TG_ZERO;
        case (addr)
            3'd0: begin
                wr_tgt = div_mode ? TG_DLL : TG_NONE;
                rd_tgt = div_mode ? TG_DLL : TG_ZERO;
            end
            3'd1: begin
                wr_tgt = div_mode ? TG_DLH : TG_IER;
                rd_tgt = wr_tgt;
            end
            3'd2: begin
                wr_tgt = key_mode ? TG_EFR : TG_FCR;
                rd_tgt = key_mode ? TG_EFR : TG_IIR;
            end
            3'd3: begin
                wr_tgt = TG_LCR;
                rd_tgt = TG_LCR;
            end
            3'd4: begin
                wr_tgt = key_mode ? TG_MDR : TG_MCR;
                rd_tgt = wr_tgt;
            end
            3'd5: begin
                wr_tgt = TG_NONE;
                rd_tgt = TG_ZERO;
            end
            3'd6: begin
                wr_tgt = trig_vis ? TG_TCR : TG_NONE;
                rd_tgt = trig_vis ? TG_TCR : TG_ZERO;
            end
            default: begin
                wr_tgt = trig_vis ? TG_TLR : TG_SPR;
                rd_tgt = wr_tgt;
            end
        endcase
    end
endmodule

// File: rtl/uart_cfg_regs.sv
// Module: register storage. Applies one host write per cycle to the decoded
// target, honouring the protected-field rules, and returns to defaults on clr.
// Assumes: wr_en already masked during soft reset; clr has priority over writes.
module uart_cfg_regs
    import uart_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  tgt_e          wr_tgt,
    input  logic [DW-1:0] wdata,
    output regs_t         q
);
    logic unlock;

    // Protected-field unlock comes from the stored extended-feature bit 4.
    always_comb unlock = q.efr[4];

    // Register update: reset, soft clear, or gated host write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= REGS_RST;
        end else if (wr_en) begin
            case (wr_tgt)
                TG_DLL: q.dll <= wdata;
                TG_DLH: q.dlh <= wdata;
                TG_IER: q.ier <= unlock ? wdata : {q.ier[7:4], wdata[3:0]};
                TG_FCR: if (unlock) q.fcr <= wdata;
                TG_LCR: q.lcr <= wdata;
                TG_MCR: q.mcr <= unlock ? wdata : {q.mcr[7:5], wdata[4:0]};
                TG_EFR: q.efr <= wdata;
                TG_MDR: q.mdr <= wdata[2:0];
                TG_TCR: q.tcr <= wdata;
                TG_TLR: q.tlr <= wdata;
                TG_SPR: q.spr <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_cfg_sreset.sv
// Module: software-reset sequencer. A start pulse holds busy for RST_CYCLES
// clocks; busy drops by itself when the count runs out.
// Assumes: start is only raised while idle.
module uart_cfg_sreset #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Down-counter loaded on start.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(RST_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Busy while the count is non-zero.
    always_comb busy = (cnt != '0);
endmodule

// File: rtl/uart_cfg_bank.sv
// Module: top of the banked configuration register file. Ties the decoder,
// storage and soft-reset sequencer together and forms read data and outputs.
// Assumes: single-cycle host write strobes; reads are combinational.
module uart_cfg_bank
    import uart_cfg_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [2:0]    host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          soft_reset_wr,
    output logic [7:0]    sys_ctrl,
    output logic [7:0]    sys_stat,
    input  logic          cts_n,
    output logic          tx_break,
    output logic          tx_hold,
    output logic          core_en,
    output logic [15:0]   baud_div,
    output logic [7:0]    fifo_cfg
);
    regs_t regs_q;
    tgt_e  wr_tgt;
    tgt_e  rd_tgt;
    logic  soft_busy;
    logic  soft_start;
    logic  clr;
    logic  wr_en;

    // Soft-reset start, clear and write masking.
    always_comb begin
        soft_start = soft_reset_wr & ~soft_busy;
        clr        = soft_start | soft_busy;
        wr_en      = host_we & ~soft_busy;
    end

    uart_cfg_decode u_dec (
        .addr       (host_addr),
        .lcr        (regs_q.lcr),
        .efr_unlock (regs_q.efr[4]),
        .mcr_trig   (regs_q.mcr[6]),
        .wr_tgt     (wr_tgt),
        .rd_tgt     (rd_tgt)
    );

    uart_cfg_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .wr_en  (wr_en),
        .wr_tgt (wr_tgt),
        .wdata  (host_wdata),
        .q      (regs_q)
    );

    uart_cfg_sreset #(.RST_CYCLES(RST_CYCLES)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (soft_start),
        .busy  (soft_busy)
    );

    // Read multiplexer driven by the decoded read target.
    always_comb begin
        case (rd_tgt)
            TG_DLL:  host_rdata = regs_q.dll;
            TG_DLH:  host_rdata = regs_q.dlh;
            TG_IER:  host_rdata = regs_q.ier;
            TG_LCR:  host_rdata = regs_q.lcr;
            TG_MCR:  host_rdata = regs_q.mcr;
            TG_EFR:  host_rdata = regs_q.efr;
            TG_MDR:  host_rdata = {5'b0, regs_q.mdr};
            TG_TCR:  host_rdata = regs_q.tcr;
            TG_TLR:  host_rdata = regs_q.tlr;
            TG_SPR:  host_rdata = regs_q.spr;
            TG_IIR:  host_rdata = 8'h01;
            default: host_rdata = 8'h00;
        endcase
    end

    // Line, enable, divisor and status outputs.
    always_comb begin
        tx_break = regs_q.lcr[6];
        tx_hold  = regs_q.efr[7] & cts_n;
        core_en  = (regs_q.mdr == 3'h0);
        baud_div = {regs_q.dlh, regs_q.dll};
        fifo_cfg = regs_q.fcr;
        sys_ctrl = {6'b0, soft_busy, 1'b0};
        sys_stat = {7'b0, ~soft_busy};
    end
endmodule

// File: rtl/uart_cfg_bank_chk.sv
// Module: assertion checker bound to uart_cfg_bank. Relates host writes,
// soft-reset activity and register state over time.
// Assumes: single-cycle write strobes and no soft-reset pulse while busy.
module uart_cfg_bank_chk
    import uart_cfg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic [2:0]  host_addr,
    input logic        soft_start,
    input logic        soft_busy,
    input regs_t       regs,
    input logic        tx_break,
    input logic        core_en,
    input logic [15:0] baud_div,
    input logic [7:0]  fifo_cfg
);
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we && !soft_start && !soft_busy) |=> $stable(baud_div)); // R2

    AST_FCR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 3'd2 && regs.lcr != ENH_KEY && !regs.efr[4]
         && !soft_start && !soft_busy) |=> $stable(fifo_cfg)); // R6

    AST_TCR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!(regs.efr[4] && regs.mcr[6]) && !soft_start && !soft_busy)
        |=> $stable(regs.tcr)); // R7

    AST_BREAK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_break) |-> $past(host_we && host_addr == 3'd3)); // R8

    AST_ENABLE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> $past(host_we && host_addr == 3'd4 && regs.lcr == ENH_KEY)); // R9

    AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_busy) |-> (regs.mdr == MODE_OFF && regs.lcr == 8'h00 && !core_en)); // R10
endmodule

bind uart_cfg_bank uart_cfg_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .soft_start (soft_start),
    .soft_busy  (soft_busy),
    .regs       (regs_q),
    .tx_break   (tx_break),
    .core_en    (core_en),
    .baud_div   (baud_div),
    .fifo_cfg   (fifo_cfg)
);

// File: tb/uart_cfg_bank_bench.sv
// Bench: table-driven register walk followed by directed output, break,
// enable and soft-reset checks.
module uart_cfg_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 4;
    localparam int NVEC       = 43;

    // Entry: {read(1)=check / 0=write, addr[3], data_or_expect[8], req[8]}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 3'd3, 8'h00, 8'd1},   // R1 line control default
        {1'b1, 3'd1, 8'h00, 8'd1},   // R1 interrupt enable default
        {1'b0, 3'd3, 8'h80, 8'd2},   // R2 divisor mode
        {1'b0, 3'd0, 8'h34, 8'd2},
        {1'b0, 3'd1, 8'h12, 8'd2},
        {1'b1, 3'd0, 8'h34, 8'd2},   // R2 low byte
        {1'b1, 3'd1, 8'h12, 8'd2},   // R2 high byte
        {1'b0, 3'd3, 8'h03, 8'd3},   // R3 back to operational
        {1'b1, 3'd0, 8'h00, 8'd3},
        {1'b1, 3'd1, 8'h00, 8'd3},
        {1'b1, 3'd3, 8'h03, 8'd3},
        {1'b0, 3'd1, 8'hFF, 8'd5},   // R5 locked high nibble
        {1'b1, 3'd1, 8'h0F, 8'd5},
        {1'b0, 3'd3, 8'hBF, 8'd4},   // R4 key mode
        {1'b0, 3'd2, 8'h10, 8'd4},
        {1'b1, 3'd2, 8'h10, 8'd4},
        {1'b1, 3'd4, 8'h07, 8'd9},   // R9 mode field default
        {1'b1, 3'd0, 8'h34, 8'd4},
        {1'b0, 3'd3, 8'h00, 8'd4},
        {1'b1, 3'd2, 8'h01, 8'd4},   // R4 status code outside key mode
        {1'b0, 3'd1, 8'hFF, 8'd5},
        {1'b1, 3'd1, 8'hFF, 8'd5},
        {1'b0, 3'd2, 8'hC7, 8'd6},   // R6 unlocked FIFO write
        {1'b0, 3'd7, 8'h5A, 8'd7},   // R7 scratch
        {1'b1, 3'd7, 8'h5A, 8'd7},
        {1'b0, 3'd6, 8'h33, 8'd7},
        {1'b1, 3'd6, 8'h00, 8'd7},   // R7 hidden threshold
        {1'b0, 3'd4, 8'h40, 8'd5},
        {1'b1, 3'd4, 8'h40, 8'd5},
        {1'b0, 3'd6, 8'h33, 8'd7},
        {1'b1, 3'd6, 8'h33, 8'd7},
        {1'b0, 3'd7, 8'h44, 8'd7},
        {1'b1, 3'd7, 8'h44, 8'd7},
        {1'b0, 3'd4, 8'h00, 8'd7},
        {1'b1, 3'd7, 8'h5A, 8'd7},   // R7 scratch kept
        {1'b1, 3'd6, 8'h00, 8'd7},
        {1'b0, 3'd3, 8'hBF, 8'd5},
        {1'b0, 3'd2, 8'h00, 8'd5},
        {1'b0, 3'd3, 8'h00, 8'd5},
        {1'b0, 3'd4, 8'hFF, 8'd5},
        {1'b1, 3'd4, 8'h1F, 8'd5},   // R5 modem control locked bits
        {1'b0, 3'd1, 8'h00, 8'd5},
        {1'b1, 3'd1, 8'hF0, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        soft_reset_wr = 1'b0;
    logic [7:0]  sys_ctrl;
    logic [7:0]  sys_stat;
    logic        cts_n = 1'b0;
    logic        tx_break;
    logic        tx_hold;
    logic        core_en;
    logic [15:0] baud_div;
    logic [7:0]  fifo_cfg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_cfg_bank #(.RST_CYCLES(RST_CYC)) u_uart_cfg_bank (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .soft_reset_wr(soft_reset_wr), .sys_ctrl(sys_ctrl), .sys_stat(sys_stat),
        .cts_n(cts_n), .tx_break(tx_break), .tx_hold(tx_hold),
        .core_en(core_en), .baud_div(baud_div), .fifo_cfg(fifo_cfg)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        host_addr = a;
        #1;
        check(req, {8'h00, host_rdata}, {8'h00, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 core_en", {15'b0, core_en}, 16'h0000);
        check("R1 tx_break", {15'b0, tx_break}, 16'h0000);
        check("R1 baud_div", baud_div, 16'h0000);
        check("R1 sys_stat", {8'h00, sys_stat}, 16'h0001);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19])
                rd($sformatf("R%0d vec%0d", VEC[i][7:0], i), VEC[i][18:16], VEC[i][15:8]);
            else
                wr(VEC[i][18:16], VEC[i][15:8]);
        end

        // R2 divisor output and byte-wise update
        check("R2 baud_div", baud_div, 16'h1234);
        wr(3'd3, 8'h80);
        wr(3'd0, 8'hAA);
        check("R2 low byte only", baud_div, 16'h12AA);
        wr(3'd3, 8'h00);

        // R6 locked FIFO write ignored
        check("R6 fifo_cfg", {8'h00, fifo_cfg}, 16'h00C7);
        wr(3'd2, 8'h81);
        check("R6 locked write", {8'h00, fifo_cfg}, 16'h00C7);

        // R9 enable through mode field
        check("R9 core_en off", {15'b0, core_en}, 16'h0000);
        wr(3'd3, 8'hBF);
        wr(3'd4, 8'h00);
        check("R9 core_en on", {15'b0, core_en}, 16'h0001);

        // R8 break independent of auto-CTS and cts_n
        wr(3'd2, 8'h80);
        wr(3'd3, 8'h40);
        cts_n = 1'b1;
        #1;
        check("R8 break cts high", {15'b0, tx_break}, 16'h0001);
        check("R8 hold cts high", {15'b0, tx_hold}, 16'h0001);
        cts_n = 1'b0;
        #1;
        check("R8 break cts low", {15'b0, tx_break}, 16'h0001);
        check("R8 hold cts low", {15'b0, tx_hold}, 16'h0000);
        wr(3'd3, 8'h00);
        check("R8 break cleared", {15'b0, tx_break}, 16'h0000);

        // R10 software reset sequence
        @(negedge clk);
        soft_reset_wr = 1'b1;
        @(negedge clk);
        soft_reset_wr = 1'b0;
        check("R10 ctrl busy", {8'h00, sys_ctrl}, 16'h0002);
        check("R10 stat busy", {8'h00, sys_stat}, 16'h0000);
        host_we = 1'b1; host_addr = 3'd3; host_wdata = 8'h55;
        @(negedge clk);
        host_we = 1'b0;
        repeat (RST_CYC - 2) @(negedge clk);
        check("R10 still busy", {8'h00, sys_stat}, 16'h0000);
        @(negedge clk);
        check("R10 done", {8'h00, sys_stat}, 16'h0001);
        check("R10 ctrl cleared", {8'h00, sys_ctrl}, 16'h0000);
        check("R10 core_en", {15'b0, core_en}, 16'h0000);
        check("R10 baud_div", baud_div, 16'h0000);
        check("R10 fifo_cfg", {8'h00, fifo_cfg}, 16'h0000);
        rd("R10 lcr default", 3'd3, 8'h00);
        wr(3'd3, 8'hBF);
        rd("R10 mode field", 3'd4, 8'h07);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule